// File: doc/BRIEF.md
# Rail Supervision Channel with Settling Mask

This block supervises one supply rail. Two digitized comparator pairs feed it: one pair for a reset-oriented supervisor level and one for a warning-oriented monitor level. Within each pair, the "fall" input reports that the rail has dropped below the lower (falling) threshold. The "rise" input reports that the rail is above the higher (rising) threshold. Each side keeps a fault state with hysteresis and a sticky flag. A recovery flag records that the rail has climbed back clear of every fault. The block derives an interrupt request and a power-on reset request from the flags and their enables.

Software configures the channel through a small write port. The analog levels, the speed mode and the enables live in a control word, and that word accepts writes only after a key is written. Any change to a level code or to the speed mode restarts a settling counter. The counter lets the analog comparators settle. While it runs, the interrupt and reset outputs are forced low and the delay-expired flag reads 0. The analog trip points themselves lie outside this block; it only drives the level codes and the mode bit toward them.

The write port is a plain single-cycle strobe with no back-pressure: a write is taken on every clock edge where `wr_en` is high. All flags are readable directly as output pins.

Top module: `svs_channel`

## Requirements
- R1: `cmp_sup_fall` high sets the supervisor flag on the next edge. `por_req_o` is high while a flag is set whose reset enable is set: the supervisor flag with control bit 9, or the monitor flag with control bit 15. With both enables clear, no reset is requested.
- R2: `cmp_mon_fall` high sets the monitor flag on the next edge. With control bit 11 set, the monitor flag raises `irq_o`.
- R3: When the last active fault (supervisor or monitor) clears, the recovery flag sets one cycle later. The recovery flag stays set until software clears it.
- R4: A fault clears only on an edge where its rise input is high and its fall input is low. A fall input that drops without a rise leaves the fault active.
- R5: A write that changes control bits [3:0] (supervisor level), [7:4] (monitor level) or [8] (fast mode) starts the settling delay. A write that changes only other bits does not start it.
- R6: While settling runs, `irq_o`, `por_req_o` and the delay-expired flag are 0. The flags themselves still set.
- R7: Settling lasts exactly DLY_SLOW cycles with bit 8 clear and DLY_FAST cycles with bit 8 set, counted from the write edge. The delay-expired flag then sets and, with control bit 13 set, raises `irq_o`. It reads 1 out of reset.
- R8: Writing 1 to a flag's clear bit zeroes that flag for one cycle. If the fault behind the flag is still active, the flag sets again on the next edge. The clear bits at address 2 are: bit 0 supervisor, 1 monitor, 2 recovery, 3 delay-expired, 4 key violation.
- R9: Writes to address 0 are key writes. A key write with 0xA5 in bits [15:8] unlocks the block when bit 0 is 0 and locks it when bit 0 is 1. Out of reset the block is locked. While locked, writes to addresses 1–3 leave all state unchanged.
- R10: A key write with any other upper byte locks the block and sets the key-violation flag. So does any write to addresses 1–3 while locked. The key-violation flag is cleared through address 2 while unlocked.
- R11: `irq_o` is the OR of each flag ANDed with its enable. The enables are: supervisor bit 10, monitor bit 11, recovery bit 12, delay-expired bit 13, key violation bit 14. `irq_o` is masked during settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_sup_fall | input | 1 | Rail below supervisor falling threshold |
| cmp_sup_rise | input | 1 | Rail above supervisor rising threshold |
| cmp_mon_fall | input | 1 | Rail below monitor falling threshold |
| cmp_mon_rise | input | 1 | Rail above monitor rising threshold |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 key, 1 control, 2 flag clear |
| wr_data | input | 16 | Write data |
| sup_level_o | output | 4 | Supervisor level code to the analog side |
| mon_level_o | output | 4 | Monitor level code to the analog side |
| fast_mode_o | output | 1 | Fast performance mode |
| sup_flag_o | output | 1 | Supervisor flag |
| mon_flag_o | output | 1 | Monitor flag |
| rec_flag_o | output | 1 | Recovery flag |
| dly_flag_o | output | 1 | Settling-delay expired flag |
| kv_flag_o | output | 1 | Key-violation flag |
| irq_o | output | 1 | Interrupt request |
| por_req_o | output | 1 | Power-on reset request |

## Verification
The key overlap is a supervisor fault that arrives while a level change is still settling. The flag must set at once, but the reset request and the interrupt must stay low until the settling count runs out. On that exact cycle both must rise together with the delay-expired flag. The bench writes new levels and raises the falling comparator on the cycle the write lands. It then checks the outputs on the first masked cycle, the last masked cycle and the first unmasked cycle. A second overlap is a software clear landing while a fault is still active. Here the bench expects the flag at 0 for exactly one cycle and back at 1 on the next.

// File: rtl/svs_pkg.sv
package svs_pkg;
  localparam int LVL_W  = 4;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam int NCLR   = 4;

  localparam logic [7:0]        KEY_VAL = 8'hA5;
  localparam logic [ADDR_W-1:0] A_KEY   = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CLR   = 2'd2;

  localparam int C_SUP = 0;
  localparam int C_MON = 1;
  localparam int C_REC = 2;
  localparam int C_DLY = 3;
  localparam int C_KV  = 4;

  typedef struct packed {
    logic             mon_rst_en;
    logic             kv_ie;
    logic             dly_ie;
    logic             rec_ie;
    logic             mon_ie;
    logic             sup_ie;
    logic             sup_rst_en;
    logic             fast;
    logic [LVL_W-1:0] mon_lvl;
    logic [LVL_W-1:0] sup_lvl;
  } ctrl_t;
endpackage

// File: rtl/svs_regs.sv
module svs_regs
  import svs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl_o,
  output logic              settle_start_o,
  output logic              settle_fast_o,
  output logic [NCLR-1:0]   clr_o,
  output logic              kv_flag_o
);
  logic  unlocked_q;
  logic  kv_q;
  ctrl_t ctrl_q;
  ctrl_t ctrl_new;
  logic  key_wr, key_ok, reg_wr, accept, viol, ctrl_wr, clr_wr, changed;

  always_comb begin
    ctrl_new = ctrl_t'(wr_data);
    key_wr   = wr_en && (wr_addr == A_KEY);
    key_ok   = (wr_data[15:8] == KEY_VAL);
    reg_wr   = wr_en && (wr_addr != A_KEY);
    accept   = reg_wr && unlocked_q;
    viol     = (key_wr && !key_ok) || (reg_wr && !unlocked_q);
    ctrl_wr  = accept && (wr_addr == A_CTRL);
    clr_wr   = accept && (wr_addr == A_CLR);
    changed  = (ctrl_new.sup_lvl != ctrl_q.sup_lvl) ||
               (ctrl_new.mon_lvl != ctrl_q.mon_lvl) ||
               (ctrl_new.fast    != ctrl_q.fast);
  end

  assign settle_start_o = ctrl_wr && changed;
  assign settle_fast_o  = ctrl_new.fast;
  assign clr_o          = clr_wr ? wr_data[NCLR-1:0] : '0;
  assign ctrl_o         = ctrl_q;
  assign kv_flag_o      = kv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      kv_q       <= 1'b0;
      ctrl_q     <= '0;
    end else begin
      if (key_wr) unlocked_q <= key_ok && !wr_data[0];
      if (viol) kv_q <= 1'b1;
      else if (clr_wr && wr_data[C_KV]) kv_q <= 1'b0;
      if (ctrl_wr) ctrl_q <= ctrl_new;
    end
  end

  AST_LOCKED_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && !unlocked_q) |=> $stable(ctrl_q)); // R9
  AST_BAD_KEY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_KEY && wr_data[15:8] != KEY_VAL) |=> (kv_q && !unlocked_q)); // R10
endmodule

// File: rtl/svs_detect.sv
module svs_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic rise_i,
  input  logic clr_i,
  output logic fault_o,
  output logic flag_o
);
  logic fault_q, flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (fall_i)      fault_q <= 1'b1;
      else if (rise_i) fault_q <= 1'b0;
      if (clr_i)                  flag_q <= 1'b0;
      else if (fall_i || fault_q) flag_q <= 1'b1;
    end
  end

  assign fault_o = fault_q;
  assign flag_o  = flag_q;

  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !rise_i) |=> fault_q); // R4
  AST_FALL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && !clr_i) |=> flag_q); // R1
  AST_REARM_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clr_i) |=> flag_q); // R8
endmodule

// File: rtl/svs_settle.sv
module svs_settle #(
  parameter int DLY_SLOW = 16,
  parameter int DLY_FAST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fast_i,
  input  logic clr_i,
  output logic settling_o,
  output logic flag_o
);
  localparam int CNT_W = $clog2(DLY_SLOW + 1);
  localparam logic [CNT_W-1:0] LOAD_SLOW = CNT_W'(DLY_SLOW);
  localparam logic [CNT_W-1:0] LOAD_FAST = CNT_W'(DLY_FAST);

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b1;
    end else if (start_i) begin
      cnt_q  <= fast_i ? LOAD_FAST : LOAD_SLOW;
      flag_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign settling_o = (cnt_q != '0);
  assign flag_o     = flag_q;

  AST_SETTLE_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> !flag_q); // R6
  AST_SETTLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(1) && !start_i) |=> (flag_q && cnt_q == '0)); // R7
endmodule

// File: rtl/svs_channel.sv
module svs_channel
  import svs_pkg::*;
#(
  parameter int DLY_SLOW = 16,
  parameter int DLY_FAST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_sup_fall,
  input  logic              cmp_sup_rise,
  input  logic              cmp_mon_fall,
  input  logic              cmp_mon_rise,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LVL_W-1:0]  sup_level_o,
  output logic [LVL_W-1:0]  mon_level_o,
  output logic              fast_mode_o,
  output logic              sup_flag_o,
  output logic              mon_flag_o,
  output logic              rec_flag_o,
  output logic              dly_flag_o,
  output logic              kv_flag_o,
  output logic              irq_o,
  output logic              por_req_o
);
  ctrl_t           ctrl;
  logic            settle_start, settle_fast, settling;
  logic [NCLR-1:0] clr;
  logic            sup_fault, mon_fault, any_fault, any_fault_q, rec_q;

  svs_regs u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .ctrl_o         (ctrl),
    .settle_start_o (settle_start),
    .settle_fast_o  (settle_fast),
    .clr_o          (clr),
    .kv_flag_o      (kv_flag_o)
  );

  svs_detect u_sup (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall_i  (cmp_sup_fall),
    .rise_i  (cmp_sup_rise),
    .clr_i   (clr[C_SUP]),
    .fault_o (sup_fault),
    .flag_o  (sup_flag_o)
  );

  svs_detect u_mon (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall_i  (cmp_mon_fall),
    .rise_i  (cmp_mon_rise),
    .clr_i   (clr[C_MON]),
    .fault_o (mon_fault),
    .flag_o  (mon_flag_o)
  );

  svs_settle #(.DLY_SLOW(DLY_SLOW), .DLY_FAST(DLY_FAST)) u_settle (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (settle_start),
    .fast_i     (settle_fast),
    .clr_i      (clr[C_DLY]),
    .settling_o (settling),
    .flag_o     (dly_flag_o)
  );

  assign any_fault = sup_fault || mon_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_fault_q <= 1'b0;
      rec_q       <= 1'b0;
    end else begin
      any_fault_q <= any_fault;
      if (any_fault_q && !any_fault) rec_q <= 1'b1;
      else if (clr[C_REC])           rec_q <= 1'b0;
    end
  end

  assign rec_flag_o  = rec_q;
  assign sup_level_o = ctrl.sup_lvl;
  assign mon_level_o = ctrl.mon_lvl;
  assign fast_mode_o = ctrl.fast;

  assign irq_o = !settling && ((sup_flag_o && ctrl.sup_ie) || (mon_flag_o && ctrl.mon_ie) ||
                               (rec_q && ctrl.rec_ie) || (dly_flag_o && ctrl.dly_ie) ||
                               (kv_flag_o && ctrl.kv_ie));
  assign por_req_o = !settling && ((sup_flag_o && ctrl.sup_rst_en) ||
                                   (mon_flag_o && ctrl.mon_rst_en));

  AST_MASK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    settling |-> (!irq_o && !por_req_o)); // R6
  AST_REC_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (any_fault_q && !any_fault) |=> rec_q); // R3
  AST_POR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    por_req_o |-> (ctrl.sup_rst_en || ctrl.mon_rst_en)); // R1
endmodule

// File: tb/svs_channel_tb.sv
`timescale 1ns/1ps
module svs_channel_tb;
  localparam int SLOW = 16;
  localparam int FAST = 4;
  localparam logic [15:0] S_SUP = 16'h0001, S_MON = 16'h0002, S_REC = 16'h0004,
                          S_DLY = 16'h0008, S_KV  = 16'h0010, S_IRQ = 16'h0020,
                          S_POR = 16'h0040, M_ALL = 16'hFFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sf = 0, sr = 0, mf = 0, mr = 0, wr_en = 0;
  logic [1:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [3:0]  sup_lvl, mon_lvl;
  logic fast, supf, monf, recf, dlyf, kvf, irq, por;
  int checks = 0, errors = 0;
  bit done = 0;
  string       q_req[$];
  logic [15:0] q_mask[$];
  logic [15:0] q_val[$];

  always #5 clk = ~clk;

  svs_channel #(.DLY_SLOW(SLOW), .DLY_FAST(FAST)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_sup_fall(sf), .cmp_sup_rise(sr),
    .cmp_mon_fall(mf), .cmp_mon_rise(mr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sup_level_o(sup_lvl), .mon_level_o(mon_lvl),
    .fast_mode_o(fast), .sup_flag_o(supf), .mon_flag_o(monf), .rec_flag_o(recf),
    .dly_flag_o(dlyf), .kv_flag_o(kvf), .irq_o(irq), .por_req_o(por));

  function automatic logic [15:0] lv(input logic [3:0] s, input logic [3:0] m, input logic f);
    return {f, m, s, 7'b0};
  endfunction

  function automatic logic [15:0] status();
    return {fast, mon_lvl, sup_lvl, por, irq, kvf, dlyf, recf, monf, supf};
  endfunction

  task automatic expect_st(input string req, input logic [15:0] mask, input logic [15:0] val);
    q_req.push_back(req); q_mask.push_back(mask); q_val.push_back(val & mask);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; wr_addr = 0; wr_data = 0;
  endtask

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk); #1;
      while (q_req.size() > 0) begin
        string r; logic [15:0] m, v, a;
        r = q_req.pop_front(); m = q_mask.pop_front(); v = q_val.pop_front();
        a = status() & m;
        checks++;
        if (a !== v) begin
          errors++;
          $display("FAIL %s status actual=%h expected=%h (mask %h)", r, a, v, m);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_st("R7 reset state", M_ALL, S_DLY);

    // locked write ignored, sets violation
    wr(2'd1, 16'hFFFF);
    expect_st("R9 locked ctrl write", M_ALL, S_DLY | S_KV);
    wr(2'd0, 16'hA500);
    wr(2'd2, 16'h0010);
    expect_st("R10 kv clear", S_KV, 16'h0);
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'h3E53);
    expect_st("R10 wrong key locks", M_ALL, S_DLY | S_KV);
    wr(2'd0, 16'hA500);
    wr(2'd2, 16'h0010);

    // level change: settling with a supervisor fault in the same window
    wr(2'd1, 16'h3E53);
    expect_st("R5 settle starts", M_ALL, lv(4'd3, 4'd5, 1'b0));
    sf = 1;
    @(negedge clk);
    expect_st("R6 first masked cycle", M_ALL, lv(4'd3, 4'd5, 1'b0) | S_SUP);
    repeat (SLOW - 2) @(negedge clk);
    expect_st("R6 last masked cycle", M_ALL, lv(4'd3, 4'd5, 1'b0) | S_SUP);
    @(negedge clk);
    expect_st("R7 slow delay end R1 por", M_ALL,
              lv(4'd3, 4'd5, 1'b0) | S_SUP | S_DLY | S_IRQ | S_POR);

    // hysteresis and re-arm
    sf = 0;
    @(negedge clk);
    expect_st("R4 fault holds without rise", S_SUP | S_POR, S_SUP | S_POR);
    wr(2'd2, 16'h0001);
    expect_st("R8 cleared cycle", S_SUP | S_POR, 16'h0);
    @(negedge clk);
    expect_st("R8 re-set next cycle", S_SUP | S_POR, S_SUP | S_POR);

    // recovery
    sr = 1;
    @(negedge clk);
    expect_st("R3 rec one cycle later", S_SUP | S_REC, S_SUP);
    sr = 0;
    @(negedge clk);
    expect_st("R3 rec set", S_REC, S_REC);
    wr(2'd2, 16'h0005);
    expect_st("R11 dly irq only", S_SUP | S_REC | S_POR | S_IRQ, S_IRQ);
    @(negedge clk);
    expect_st("R4 stays clear after rise", S_SUP | S_REC | S_POR, 16'h0);

    // non-level change: no settling
    wr(2'd1, 16'h1E53);
    expect_st("R5 no settle on enable change", 16'hFF80 | S_DLY | S_IRQ,
              lv(4'd3, 4'd5, 1'b0) | S_DLY);

    // monitor
    mf = 1;
    @(negedge clk);
    mf = 0;
    expect_st("R2 monitor flag irq", S_MON | S_IRQ | S_POR, S_MON | S_IRQ);
    wr(2'd2, 16'h0002);
    expect_st("R8 monitor cleared", S_MON, 16'h0);
    @(negedge clk);
    expect_st("R8 monitor re-set", S_MON, S_MON);
    mr = 1;
    @(negedge clk);
    mr = 0;
    @(negedge clk);
    expect_st("R3 rec after monitor", S_REC, S_REC);
    wr(2'd2, 16'h0006);
    expect_st("R11 all clear no irq", S_MON | S_REC | S_IRQ, 16'h0);

    // fast mode settling
    wr(2'd1, 16'h7953);
    expect_st("R5 mode change settles", M_ALL, lv(4'd3, 4'd5, 1'b1));
    repeat (FAST - 1) @(negedge clk);
    expect_st("R7 fast still masked", S_DLY | S_IRQ, 16'h0);
    @(negedge clk);
    expect_st("R7 fast delay end", S_DLY | S_IRQ, S_DLY | S_IRQ);

    // supervisor fault without reset enable
    sf = 1;
    @(negedge clk);
    sf = 0;
    expect_st("R1 no por without enable", S_SUP | S_POR, S_SUP);
    wr(2'd2, 16'h0008);
    expect_st("R11 flag without enable", S_DLY | S_IRQ, 16'h0);

    // relock then violation interrupt
    wr(2'd0, 16'hA501);
    wr(2'd1, 16'h0000);
    expect_st("R10 kv irq after relock R9", M_ALL,
              lv(4'd3, 4'd5, 1'b1) | S_SUP | S_KV | S_IRQ);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule